// File: doc/BRIEF.md
# Half-Duplex Byte SPI Master

This block is a register-mapped SPI master that moves one byte per transfer over a single serial link with one chip-select line. Host software programs a configuration register, loads a transmit byte, and sets a start bit. It then polls a busy flag and reads the captured byte. Software owns the chip-select line through a control bit, so several bytes can be framed under one select.

The serial clock is the system clock divided by a power of two between 2 and 128. The divisor is held as a 3-bit log2 code. The clock phase is not a single phase bit. Instead, the configuration has an idle-polarity bit plus two separate bits, one choosing the falling edge for launching data and one choosing the falling edge for sampling it. Bit order is also selectable.

The register port is a plain single-cycle write strobe with a combinational read. It has no valid/ready handshake and no back-pressure, because every access completes in the cycle it is presented. Transfer pacing is done entirely by polling the busy flag.

Top module: `spi_half_master`

## Requirements
- R1: After reset, the configuration register (address 0) reads 0x37, the control register (address 1) reads 0x03, and status (address 3) and received data (address 2) read 0. At the pins, chip select is high, SCLK is high and the data-out enable is low.
- R2: Configuration register bit fields: bit 0 selects MSB first, bit 1 is the idle clock polarity, bit 2 selects the falling edge for transmit launch, bit 3 selects the falling edge for receive capture, and bits 6:4 hold the prescale code p.
- R3: A transfer lasts 16·2^p system clocks, which is a serial clock of clk/2^(p+1). A code of 7 is treated as 6, so the slowest rate is clk/128.
- R4: When the MSB-first bit is set, bit 7 goes out first and the first received bit lands in bit 7. When the bit is clear, bit 0 leads in both directions.
- R5: Data is captured on the edge chosen by the receive-edge bit and launched on the edge chosen by the transmit-edge bit. The first bit is already on MOSI at start, so a launch edge that comes before any capture does not shift. This covers all four SPI modes: (pol,tx,rx) = (0,1,0), (0,0,1), (1,0,1), (1,1,0).
- R6: Control register bits are: bit 0 enable, bit 1 data-out tri-state, bit 2 chip select, and bit 3 start (write-only, reads 0). A write with start=1 and enable=1 begins a transfer and sets status bit 0 (busy). A start while busy, or without enable, is ignored.
- R7: The received-data register changes only when a transfer completes. It keeps its old value while a transfer is in progress.
- R8: Writes to the configuration or transmit-data registers during a transfer do not affect the transfer in progress. Settings are taken at the next start.
- R9: The data-out enable is high during a transfer, or whenever the tri-state bit is clear. Otherwise it is low.
- R10: The chip-select pin is active low and equals the inverse of control bit 2 from the cycle after the write.
- R11: When no transfer is active, SCLK sits at the configured polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 config, 1 control, 2 data, 3 status) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_mosi_oe | output | 1 | Output enable for spi_mosi |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
A wrong edge-role decode or bit-order state shows up as a mis-assembled byte. It appears both in the value the bench slave collects from MOSI and in the received-data register, both read out as soon as busy drops. A divider that counts wrongly, or a transfer that restarts, changes the exact number of polls for which busy reads 1, or leaves the slave with more than eight clocked bits. Latched settings that leak from the live registers are caught on the one transfer where configuration and transmit data are rewritten while busy.

// File: rtl/spi_hm_pkg.sv
`timescale 1ns/1ps
package spi_hm_pkg;
  localparam int DATA_W    = 8;
  localparam int PRESC_W   = 3;
  localparam int PRESC_MAX = 6;
  localparam int ADDR_W    = 2;

  localparam logic [ADDR_W-1:0] A_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTL  = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic               rx_fall;
    logic               tx_fall;
    logic               cpol;
    logic               msb_first;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
  localparam cfg_t CFG_RESET = '{presc: 3'd3, rx_fall: 1'b0, tx_fall: 1'b1,
                                 cpol: 1'b1, msb_first: 1'b1};
endpackage

// File: rtl/spi_hm_regs.sv
`timescale 1ns/1ps
module spi_hm_regs
  import spi_hm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_byte,
  output cfg_t              cfg,
  output logic [DATA_W-1:0] tx_byte,
  output logic [DATA_W-1:0] rx_q,
  output logic              hiz,
  output logic              cs,
  output logic              start_go
);
  logic en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= CFG_RESET;
      en      <= 1'b1;
      hiz     <= 1'b1;
      cs      <= 1'b0;
      tx_byte <= '0;
      rx_q    <= '0;
    end else begin
      if (wr) begin
        case (addr)
          A_CFG:  cfg <= cfg_t'(wdata[CFG_W-1:0]);
          A_CTL: begin
            en  <= wdata[0];
            hiz <= wdata[1];
            cs  <= wdata[2];
          end
          A_DATA: tx_byte <= wdata;
          default: ;
        endcase
      end
      if (done) rx_q <= rx_byte;
    end
  end

  // start needs enable in the same write and an idle engine
  assign start_go = wr && (addr == A_CTL) && wdata[3] && wdata[0] && !busy;

  always_comb begin
    case (addr)
      A_CFG:   rdata = {{(DATA_W-CFG_W){1'b0}}, cfg};
      A_CTL:   rdata = {{(DATA_W-3){1'b0}}, cs, hiz, en};
      A_DATA:  rdata = rx_q;
      default: rdata = {{(DATA_W-1){1'b0}}, busy};
    endcase
  end
endmodule

// File: rtl/spi_hm_clkdiv.sv
`timescale 1ns/1ps
module spi_hm_clkdiv
  import spi_hm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);
  localparam int CW = (PRESC_MAX > 0) ? PRESC_MAX : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb lim = CW'((32'd1 << presc) - 32'd1);

  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_hm_shifter.sv
`timescale 1ns/1ps
module spi_hm_shifter
  import spi_hm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  cfg_t              cfg_in,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sclk,
  output logic              mosi,
  output cfg_t              act
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);
  localparam int KW    = $clog2(DATA_W + 1);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

  logic              ph;
  logic [EW-1:0]     edge_cnt;
  logic [KW-1:0]     cap_cnt;
  logic [DATA_W-1:0] tx_sh, rx_sh, tx_nxt, rx_nxt;
  logic              step, is_fall, cap, launch;

  assign sclk    = ph ^ act.cpol;
  assign step    = tick && busy;
  assign is_fall = sclk;                 // level before the toggle is high
  assign cap     = step && (is_fall == act.rx_fall);
  assign launch  = step && (is_fall == act.tx_fall) && (cap_cnt != '0);
  assign done    = step && (edge_cnt == LAST_EDGE);

  always_comb begin
    if (act.msb_first) begin
      rx_nxt = {rx_sh[DATA_W-2:0], miso};
      tx_nxt = tx_sh << 1;
    end else begin
      rx_nxt = {miso, rx_sh[DATA_W-1:1]};
      tx_nxt = tx_sh >> 1;
    end
  end

  assign rx_byte = cap ? rx_nxt : rx_sh;
  assign mosi    = act.msb_first ? tx_sh[DATA_W-1] : tx_sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      act      <= CFG_RESET;
      ph       <= 1'b0;
      edge_cnt <= '0;
      cap_cnt  <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else if (go) begin
      busy      <= 1'b1;
      act       <= cfg_in;
      act.presc <= (cfg_in.presc > PRESC_W'(PRESC_MAX)) ? PRESC_W'(PRESC_MAX) : cfg_in.presc;
      ph        <= 1'b0;
      edge_cnt  <= '0;
      cap_cnt   <= '0;
      tx_sh     <= tx_byte;
      rx_sh     <= '0;
    end else if (step) begin
      ph       <= ~ph;
      edge_cnt <= edge_cnt + 1'b1;
      if (cap) begin
        rx_sh   <= rx_nxt;
        cap_cnt <= cap_cnt + 1'b1;
      end
      if (launch) tx_sh <= tx_nxt;
      if (done)   busy  <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_half_master.sv
`timescale 1ns/1ps
module spi_half_master
  import spi_hm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic              spi_mosi_oe,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  cfg_t              cfg, act;
  logic [DATA_W-1:0] tx_byte, rx_byte, rx_q;
  logic              hiz, cs, start_go, busy, done, tick, eng_sclk;

  spi_hm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .done(done), .rx_byte(rx_byte),
    .cfg(cfg), .tx_byte(tx_byte), .rx_q(rx_q), .hiz(hiz), .cs(cs),
    .start_go(start_go)
  );

  spi_hm_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .presc(act.presc), .tick(tick)
  );

  spi_hm_shifter u_eng (
    .clk(clk), .rst_n(rst_n), .go(start_go), .cfg_in(cfg), .tx_byte(tx_byte),
    .tick(tick), .miso(spi_miso), .busy(busy), .done(done), .rx_byte(rx_byte),
    .sclk(eng_sclk), .mosi(spi_mosi), .act(act)
  );

  assign spi_sclk    = busy ? eng_sclk : cfg.cpol;
  assign spi_mosi_oe = busy || !hiz;
  assign spi_cs_n    = !cs;
endmodule

// File: rtl/spi_half_master_chk.sv
`timescale 1ns/1ps
module spi_half_master_chk
  import spi_hm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              spi_sclk,
  input logic              spi_mosi_oe,
  input logic              spi_cs_n,
  input logic              busy,
  input logic              done,
  input logic              hiz,
  input cfg_t              cfg,
  input cfg_t              act,
  input logic [DATA_W-1:0] rx_q
);
  // R6
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_addr == A_CTL && reg_wdata[3] && reg_wdata[0]));

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R7
  rx_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_q) |-> $past(done));

  // R8
  act_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(act));

  // R9
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && hiz) |-> !spi_mosi_oe);

  // R10
  cs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTL) |=> (spi_cs_n == !$past(reg_wdata[2])));

  // R11
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_sclk == cfg.cpol));
endmodule

bind spi_half_master spi_half_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .spi_sclk(spi_sclk), .spi_mosi_oe(spi_mosi_oe),
  .spi_cs_n(spi_cs_n), .busy(busy), .done(done), .hiz(hiz), .cfg(cfg),
  .act(act), .rx_q(rx_q)
);

// File: tb/spi_half_master_tb.sv
`timescale 1ns/1ps
module spi_half_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {config, master tx byte, slave tx byte}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h05_A5_3C, 24'h19_81_7E, 24'h2B_01_80, 24'h37_F0_0F,
    24'h04_A5_3C, 24'h28_C3_5A, 24'h1A_6E_91, 24'h06_FF_00
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       spi_sclk, spi_mosi, spi_mosi_oe, spi_miso, spi_cs_n;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_half_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_mosi_oe(spi_mosi_oe), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  // bench slave: samples on the master's capture edge, shifts on its launch edge
  bit         sl_msb = 1'b1, sl_txf = 1'b1, sl_rxf = 1'b0;
  logic [7:0] sl_sh = 8'h00, sl_rx = 8'h00;
  int         sl_cnt = 0;
  assign spi_miso = sl_msb ? sl_sh[7] : sl_sh[0];

  always @(spi_sclk) begin
    if (rst_n && !spi_cs_n) begin
      automatic bit f = (spi_sclk == 1'b0);
      automatic int c = sl_cnt;
      if (f == sl_rxf) begin
        sl_rx  = sl_msb ? {sl_rx[6:0], spi_mosi} : {spi_mosi, sl_rx[7:1]};
        sl_cnt = sl_cnt + 1;
      end
      if (f == sl_txf && c != 0) sl_sh = sl_msb ? (sl_sh << 1) : (sl_sh >> 1);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle(output int ones);
    logic [7:0] s;
    ones = 0;
    forever begin
      rd(2'd3, s);
      if (!s[0]) break;
      ones++;
      if (ones > 5000) break;
    end
  endtask

  task automatic slave_setup(input logic [7:0] c, input logic [7:0] b);
    sl_msb = c[0]; sl_txf = c[2]; sl_rxf = c[3];
    sl_sh = b; sl_rx = 8'h00; sl_cnt = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d, prev;
    int ones;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, d); check("R1 cfg", d, 8'h37);
    rd(2'd1, d); check("R1 ctl", d, 8'h03);
    rd(2'd3, d); check("R1 status", d, 8'h00);
    rd(2'd2, d); check("R1 rxdata", d, 8'h00);
    check("R1 cs_n", spi_cs_n, 1);
    check("R1 sclk", spi_sclk, 1);
    check("R1 mosi_oe", spi_mosi_oe, 0);

    // R2 R4 R5 vector walk over modes, orders and prescales
    for (int i = 0; i < NVEC; i++) begin
      logic [23:0] v = VEC[i];
      slave_setup(v[23:16], v[7:0]);
      wr(2'd0, v[23:16]);
      wr(2'd2, v[15:8]);
      wr(2'd1, 8'h07);
      wr(2'd1, 8'h0F);
      wait_idle(ones);
      rd(2'd2, d);
      check($sformatf("R5 R4 vec%0d master rx", i), d, v[7:0]);
      check($sformatf("R5 R4 vec%0d slave rx", i), sl_rx, v[15:8]);
      check($sformatf("R5 vec%0d bit count", i), sl_cnt, 8);
      check($sformatf("R3 vec%0d duration", i), ones, (16 << v[22:20]) - 1);
      wr(2'd1, 8'h03);
    end

    // R11 idle polarity follows config
    wr(2'd0, 8'h05); check("R11 sclk idle pol0", spi_sclk, 0);
    wr(2'd0, 8'h07); check("R11 sclk idle pol1", spi_sclk, 1);

    // R3 slowest rate and clamp of code 7
    foreach (VEC[k]) if (k < 2) begin
      logic [7:0] c = (k == 0) ? 8'h65 : 8'h75;
      slave_setup(c, 8'h00);
      wr(2'd0, c); wr(2'd1, 8'h07); wr(2'd1, 8'h0F);
      wait_idle(ones);
      check("R3 div128 duration", ones, 1023);
      wr(2'd1, 8'h03);
    end

    // R9 output enable with tri-state bit clear
    wr(2'd1, 8'h01); check("R9 oe tri-state off", spi_mosi_oe, 1);
    wr(2'd1, 8'h03); check("R9 oe tri-state on", spi_mosi_oe, 0);

    // R10 chip select
    wr(2'd1, 8'h07); check("R10 cs asserted", spi_cs_n, 0);
    wr(2'd1, 8'h03); check("R10 cs released", spi_cs_n, 1);

    // R6 start without enable is ignored
    wr(2'd1, 8'h0A);
    rd(2'd3, d); check("R6 no start when disabled", d, 8'h00);
    rd(2'd1, d); check("R6 start bit reads 0", d, 8'h02);
    wr(2'd1, 8'h03);

    // R6 R7 R8 rewrites during a transfer
    rd(2'd2, prev);
    slave_setup(8'h65, 8'h5A);
    wr(2'd0, 8'h65); wr(2'd2, 8'hC3); wr(2'd1, 8'h07); wr(2'd1, 8'h0F);
    rd(2'd3, d); check("R6 busy set", d, 8'h01);
    check("R9 oe while busy", spi_mosi_oe, 1);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h0F);
    wr(2'd0, 8'h04);
    rd(2'd2, d); check("R7 rx held while busy", d, prev);
    wait_idle(ones);
    rd(2'd2, d); check("R8 master rx after rewrite", d, 8'h5A);
    check("R8 slave rx after rewrite", sl_rx, 8'hC3);
    check("R6 no restart while busy", sl_cnt, 8);
    wr(2'd1, 8'h03);

    summary();
  end
endmodule